// File: doc/BRIEF.md
# PHY Management Interface Controller

This block runs one serial management transaction at a time toward an Ethernet PHY. Software writes a single 32-bit command word over a plain register write port. The word holds the PHY address, the PHY register number, sixteen bits of write data and two start bits, one for a read and one for a write. The block then generates the management clock and shifts out a complete frame on the bidirectional data line. It holds a busy flag while the frame is in progress. When a read finishes, it places the returned sixteen bits in the upper half of the same word, together with a flag that marks the read as failed.

The management clock comes from the system clock. It toggles every `MDC_HALF_DIV` system cycles, and only while a frame is in progress. The data line is split into output, output-enable and input pins, so that an external pad can form the tri-state buffer. Each frame is made of the following parts, in order:

- a preamble of `PREAMBLE_BITS` ones;
- the start code `01`;
- the opcode;
- the two addresses;
- a two-bit turnaround;
- sixteen data bits.

Every field is sent MSB first. The block drives the line only on falling clock edges and samples it on rising edges.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads the `PHY_ADDR_RST` value in bits 15:11 and zero in every other bit, and both `mdc` and `mdio_oe` are low.
- R2: A register write accepted while idle loads bits 31:16 (data), 15:11 (PHY address) and 10:6 (register number), and these read back at the same positions from the next cycle on. A write with neither start bit set starts nothing.
- R3: A write with bit 1 or bit 0 set, accepted while idle, makes the busy flag (bit 3) read 1 from the next cycle. Busy stays 1 until exactly `PREAMBLE_BITS`+32 rising `mdc` edges have been produced.
- R4: A write transaction (bit 0) sends the following on `mdio_o`, sampled at each rising `mdc` edge, with `mdio_oe` high for all bits:
  - 32 ones;
  - `01`;
  - opcode `01`;
  - the PHY address;
  - the register number;
  - turnaround `10`;
  - the data field.
- R5: A read transaction (bit 1) sends the preamble, `01`, opcode `10` and both addresses with `mdio_oe` high. It then holds `mdio_oe` low for the 2 turnaround bits and the 16 data bits.
- R6: At the end of a read, bits 31:16 hold the 16 bits sampled from `mdio_i` on the last 16 rising `mdc` edges, the first sampled bit in bit 31.
- R7: The not-valid flag (bit 4) is set after a read in which `mdio_i` was high at the second turnaround bit. The flag is cleared when a transaction starts, and it stays clear after a write.
- R8: A register write that arrives while busy is set has no effect on any field, on the frame in progress, or on what runs after it.
- R9: While idle, `mdc` and `mdio_oe` are low. `mdc` has a period of 2×`MDC_HALF_DIV` system cycles. While `mdio_oe` stays high, `mdio_o` changes only in the cycle in which `mdc` falls.
- R10: A write with both bits 1 and 0 set runs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written |
| reg_rdata | output | 32 | Command/status word read back |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data value driven toward the PHY |
| mdio_oe | output | 1 | Enable for the data line driver |
| mdio_i | input | 1 | Data value seen on the line |

## Verification
Some rules can be checked on every cycle from the ports alone, and the assertions cover these. The management clock and the line driver must be quiet while idle, and a clock edge may only appear while busy. The output data may change only on a falling clock edge, a start bit must raise busy, an idle write must load the fields, and a write during busy must leave them alone. Other behaviour needs a frame to be observed in full, so only the bench scenarios show it. This covers the bit-by-bit frame content, the release point of a read, the exact count of clock edges, the returned read data and the not-valid flag. The bench uses a modelled PHY and checks these across random addresses and data, bad turnarounds, both start bits set, and a command written in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Field positions of the command/status word
    localparam int DATA_MSB   = 31;
    localparam int DATA_LSB   = 16;
    localparam int PHY_MSB    = 15;
    localparam int PHY_LSB    = 11;
    localparam int REG_MSB    = 10;
    localparam int REG_LSB    = 6;
    localparam int NVALID_BIT = 4;
    localparam int BUSY_BIT   = 3;
    localparam int RD_BIT     = 1;
    localparam int WR_BIT     = 0;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] WRAP_VAL = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == WRAP_VAL);
        rise = run && wrap && !s_q.mdc;
        fall = run && wrap && s_q.mdc;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = !s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              done_read,
    output logic [DATA_W-1:0] rx_data,
    output logic              ta_bad
);
    localparam int FRAME_LEN = PREAMBLE_BITS + 32;
    localparam int CW        = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] TA1_IDX  = CW'(PREAMBLE_BITS + 14);
    localparam logic [CW-1:0] TA2_IDX  = CW'(PREAMBLE_BITS + 15);
    localparam logic [CW-1:0] DAT0_IDX = CW'(PREAMBLE_BITS + 16);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_LEN - 1);

    typedef struct packed {
        logic                 busy;
        logic                 last;
        logic                 is_read;
        logic [CW-1:0]        idx;
        logic [FRAME_LEN-1:0] sh;
        logic                 oe;
        logic [DATA_W-1:0]    rx;
        logic                 ta_bad;
    } shf_t;

    shf_t       s_d, s_q;
    mdio_op_e   op;
    logic [1:0] ta_pat;
    logic [CW-1:0] nxt_idx;

    always_comb begin
        s_d     = s_q;
        done    = 1'b0;
        op      = start_read ? OP_READ : OP_WRITE;
        ta_pat  = start_read ? 2'b11 : 2'b10;
        nxt_idx = s_q.idx + 1'b1;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.last    = 1'b0;
                s_d.is_read = start_read;
                s_d.idx     = '0;
                s_d.sh      = {{PREAMBLE_BITS{1'b1}}, 2'b01, op, phy_addr, reg_addr,
                               ta_pat, wr_data};
                s_d.oe      = 1'b1;
                s_d.rx      = '0;
                s_d.ta_bad  = 1'b0;
            end
        end else begin
            if (rise) begin
                if (s_q.is_read && s_q.idx == TA2_IDX) s_d.ta_bad = mdio_i;
                if (s_q.is_read && s_q.idx >= DAT0_IDX) s_d.rx = {s_q.rx[DATA_W-2:0], mdio_i};
                if (s_q.idx == LAST_IDX) s_d.last = 1'b1;
            end
            if (fall) begin
                if (s_q.last) begin
                    s_d.busy = 1'b0;
                    s_d.last = 1'b0;
                    s_d.oe   = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.idx = nxt_idx;
                    s_d.sh  = {s_q.sh[FRAME_LEN-2:0], 1'b0};
                    s_d.oe  = !s_q.is_read || (nxt_idx < TA1_IDX);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign mdio_o    = s_q.sh[FRAME_LEN-1];
    assign mdio_oe   = s_q.oe;
    assign done_read = s_q.is_read;
    assign rx_data   = s_q.rx;
    assign ta_bad    = s_q.ta_bad;

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR_RST = 5'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_read,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ta_bad,
    output logic              start,
    output logic              start_read,
    output logic [31:0]       reg_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic              nvalid;
    } cmd_t;

    cmd_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d        = s_q;
        accept     = reg_wr && !busy;
        start      = accept && (reg_wdata[RD_BIT] || reg_wdata[WR_BIT]);
        start_read = reg_wdata[RD_BIT];
        if (accept) begin
            s_d.data  = reg_wdata[DATA_MSB:DATA_LSB];
            s_d.phy   = reg_wdata[PHY_MSB:PHY_LSB];
            s_d.regad = reg_wdata[REG_MSB:REG_LSB];
            if (start) s_d.nvalid = 1'b0;
        end
        if (done && done_read) begin
            s_d.data   = rx_data;
            s_d.nvalid = ta_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.phy    <= PHY_ADDR_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata                    = '0;
        reg_rdata[DATA_MSB:DATA_LSB] = s_q.data;
        reg_rdata[PHY_MSB:PHY_LSB]   = s_q.phy;
        reg_rdata[REG_MSB:REG_LSB]   = s_q.regad;
        reg_rdata[NVALID_BIT]        = s_q.nvalid;
        reg_rdata[BUSY_BIT]          = busy;
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int               MDC_HALF_DIV  = 4,
    parameter int               PREAMBLE_BITS = 32,
    parameter logic [4:0]       PHY_ADDR_RST  = 5'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy, start, start_read, rise, fall;
    logic              done, done_read, ta_bad;
    logic [DATA_W-1:0] rx_data;

    mdio_cmd_reg #(
        .PHY_ADDR_RST(PHY_ADDR_RST)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .done      (done),
        .done_read (done_read),
        .rx_data   (rx_data),
        .ta_bad    (ta_bad),
        .start     (start),
        .start_read(start_read),
        .reg_rdata (reg_rdata)
    );

    mdio_clk_div #(
        .HALF_DIV(MDC_HALF_DIV)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_shifter #(
        .PREAMBLE_BITS(PREAMBLE_BITS)
    ) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_read(start_read),
        .phy_addr  (reg_wdata[PHY_MSB:PHY_LSB]),
        .reg_addr  (reg_wdata[REG_MSB:REG_LSB]),
        .wr_data   (reg_wdata[DATA_MSB:DATA_LSB]),
        .rise      (rise),
        .fall      (fall),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .done_read (done_read),
        .rx_data   (rx_data),
        .ta_bad    (ta_bad)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        mdio_i
);
    logic busy;
    assign busy = reg_rdata[3];

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && (reg_wdata[1] || reg_wdata[0])) |=> busy); // R3

    AST_IDLE_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr) |=> (reg_rdata[15:6] == $past(reg_wdata[15:6]))); // R2

    AST_PLAIN_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_wr && !reg_wdata[1] && !reg_wdata[0]) |=> !busy); // R2

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(reg_rdata[15:6])); // R8

    AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R9

    AST_MDC_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy); // R9

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mdio_oe) && mdio_oe && !$stable(mdio_o)) |-> $fell(mdc)); // R9

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .mdio_i   (mdio_i)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
    localparam int         DIV     = 4;
    localparam logic [4:0] PHY_RST = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int fails = 0;
    int rise_cnt = 0;
    int base = 0;
    int cyc = 0;
    int rise_cyc [0:63];
    logic rec_o  [0:63];
    logic rec_oe [0:63];
    logic [63:0] resp = '1;
    logic mdc_prev = 1'b0;
    int rel;

    mdio_mgmt_ctrl #(
        .MDC_HALF_DIV (DIV),
        .PREAMBLE_BITS(32),
        .PHY_ADDR_RST (PHY_RST)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .mdio_i   (mdio_i)
    );

    always #2.5 clk = ~clk;

    // Modelled PHY: bit k of the current frame is presented before rising edge k
    assign rel    = rise_cnt - base;
    assign mdio_i = (rel >= 0 && rel < 64) ? resp[63 - rel] : 1'b1;

    always @(negedge clk) begin : monitor
        int k;
        cyc = cyc + 1;
        if (mdc && !mdc_prev) begin
            k = rise_cnt - base;
            if (k >= 0 && k < 64) begin
                rec_o[k]    = mdio_o;
                rec_oe[k]   = mdio_oe;
                rise_cyc[k] = cyc;
            end
            rise_cnt = rise_cnt + 1;
        end
        mdc_prev = mdc;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b11 : 2'b10), d};
    endfunction

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // rd: read transaction; both: set both start bits; bad: PHY leaves TA2 high;
    // intrude: write another command in the middle of the frame
    task automatic run_txn(input bit rd, input bit both, input logic [4:0] p,
                           input logic [4:0] r, input logic [15:0] d,
                           input bit bad, input bit intrude);
        logic [31:0] cmd;
        logic [63:0] fr;
        bit          eff_rd;
        int          n, lim, bad_bits, bad_oe;
        eff_rd = rd || both;
        cmd = {(eff_rd ? ~d : d), p, r, 4'b0000, eff_rd, (!rd || both)};
        resp = '1;
        if (eff_rd) begin
            resp[63 - 47] = bad;
            resp[15:0]    = d;
        end
        base = rise_cnt;
        write_reg(cmd);
        check(reg_rdata[3] == 1'b1, "R3", "busy after start", {63'd0, reg_rdata[3]}, 64'd1);
        if (intrude) begin
            repeat (60) @(negedge clk);
            write_reg({~d, ~p, ~r, 4'b0000, 1'b0, 1'b1});
            check(reg_rdata[15:6] == {p, r}, "R8", "fields during busy",
                  {54'd0, reg_rdata[15:6]}, {54'd0, p, r});
        end
        n = 0;
        while (reg_rdata[3] && n < 400 * DIV) begin
            @(negedge clk);
            n++;
        end
        check(reg_rdata[3] == 1'b0, "R3", "busy clears", {63'd0, reg_rdata[3]}, 64'd0);
        check(rise_cnt - base == 64, "R3", "mdc rising edges", 64'(rise_cnt - base), 64'd64);
        check(!mdc && !mdio_oe, "R9", "idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
        check(rise_cyc[1] - rise_cyc[0] == 2 * DIV, "R9", "mdc period",
              64'(rise_cyc[1] - rise_cyc[0]), 64'(2 * DIV));
        fr  = exp_frame(eff_rd, p, r, d);
        lim = eff_rd ? 46 : 64;
        bad_bits = 0;
        bad_oe   = 0;
        for (int k = 0; k < 64; k++) begin
            if (k < lim && rec_o[k] !== fr[63 - k]) bad_bits++;
            if (rec_oe[k] !== (k < lim)) bad_oe++;
        end
        if (eff_rd) begin
            check(bad_bits == 0, (both ? "R10" : "R5"), "read frame bits", 64'(bad_bits), 64'd0);
            check(bad_oe == 0, (both ? "R10" : "R5"), "read release of mdio", 64'(bad_oe), 64'd0);
            check(reg_rdata[31:16] == d, "R6", "read data", {48'd0, reg_rdata[31:16]}, {48'd0, d});
            check(reg_rdata[4] == bad, "R7", "not-valid after read", {63'd0, reg_rdata[4]}, {63'd0, bad});
        end else begin
            check(bad_bits == 0, "R4", "write frame bits", 64'(bad_bits), 64'd0);
            check(bad_oe == 0, "R4", "write drive enable", 64'(bad_oe), 64'd0);
            check(reg_rdata[31:16] == d, "R2", "data field after write",
                  {48'd0, reg_rdata[31:16]}, {48'd0, d});
            check(reg_rdata[4] == 1'b0, "R7", "not-valid after write", {63'd0, reg_rdata[4]}, 64'd0);
        end
        check(reg_rdata[15:6] == {p, r}, (intrude ? "R8" : "R2"), "address fields",
              {54'd0, reg_rdata[15:6]}, {54'd0, p, r});
        if (intrude) begin
            repeat (4 * DIV) @(negedge clk);
            check(reg_rdata[3] == 1'b0 && !mdc, "R8", "no queued transaction",
                  {62'd0, reg_rdata[3], mdc}, 64'd0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R3 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin : stimulus
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(reg_rdata == {16'h0, PHY_RST, 11'h0}, "R1", "reset word",
              {32'd0, reg_rdata}, {32'd0, 16'h0, PHY_RST, 11'h0});
        check(!mdc && !mdio_oe, "R1", "reset lines", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2: idle write with no start bit only loads fields
        write_reg({16'hBEEF, 5'd9, 5'd17, 6'b000000});
        repeat (3) @(negedge clk);
        check(reg_rdata == {16'hBEEF, 5'd9, 5'd17, 6'b000000}, "R2", "plain field write",
              {32'd0, reg_rdata}, {32'd0, 16'hBEEF, 5'd9, 5'd17, 6'b000000});
        check(!mdc && rise_cnt == 0, "R2", "no frame from plain write",
              {63'd0, mdc}, 64'd0);

        // Directed corner cases
        run_txn(1'b0, 1'b0, 5'd1,  5'd0,  16'h8000, 1'b0, 1'b0); // R4 write
        run_txn(1'b1, 1'b0, 5'd31, 5'd31, 16'hA5C3, 1'b0, 1'b0); // R5 R6 read
        run_txn(1'b1, 1'b0, 5'd0,  5'd1,  16'h0001, 1'b1, 1'b0); // R7 failed read
        run_txn(1'b1, 1'b0, 5'd2,  5'd3,  16'hFFFF, 1'b0, 1'b0); // R7 clears again
        run_txn(1'b1, 1'b1, 5'd5,  5'd9,  16'h1234, 1'b0, 1'b0); // R10 both bits
        run_txn(1'b1, 1'b0, 5'd7,  5'd4,  16'h0F0F, 1'b0, 1'b1); // R8 write during busy

        // Random transactions
        for (int i = 0; i < 10; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            run_txn(rv[0], 1'b0, rv[5:1], rv[10:6], rv[31:16], (rv[12:11] == 2'b00), 1'b0);
        end
        finish_run();
    end

endmodule